// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the low-power state of a small microcontroller core. When the core retires a sleep instruction it raises a strobe. If no enabled interrupt is waiting at that moment, the controller does three things. It stops the oscillator and the core clock, it pulses a clear to the watchdog, and it updates two status flags. The power-down flag goes to 0 and the time-out flag goes to 1. If an enabled interrupt is already waiting, the sleep strobe is treated as a no-op and nothing changes.

Sleep ends in one of three ways: an enabled interrupt, a watchdog time-out, or the external reset pin. Interrupt and watchdog wakes restart the oscillator. In crystal mode the controller then waits a parameterised start-up interval; in RC mode it does not wait. It then re-enables the core clock and raises a one-cycle resume pulse. A companion bit on that pulse tells the core what to do next:
- continue in line, or
- execute the next instruction, take a dummy cycle and vector to the interrupt address.

The core vectors only when the wake was caused by an interrupt and the global interrupt enable was set. An external reset forces a core reset immediately and leaves the status flags untouched.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, pwrdn_flag_o=1, tmo_flag_o=1, osc_en_o=1, core_clk_en_o=1, resume_o=0, core_rst_o=0 and wdt_clr_o=0.
- R2: A sleep_i strobe while awake, with no source having both irq_flag_i[k] and irq_en_i[k] set, produces the following on the next edge: pwrdn_flag_o=0, tmo_flag_o=1, osc_en_o=0 and core_clk_en_o=0. On that same edge wdt_clr_o goes high, and it is high for exactly one cycle.
- R3: A sleep_i strobe while some source k has both irq_flag_i[k] and irq_en_i[k] set is a no-op. Both flags keep their values, wdt_clr_o stays 0, and the oscillator and core clock stay on.
- R4: While asleep, any source with both its flag and its enable set ends sleep, whatever the value of irq_global_en_i. A flag whose enable is 0 has no effect, and osc_en_o stays 0.
- R5: While asleep, a wdt_timeout_i pulse ends sleep and clears tmo_flag_o on the next edge. The resume that follows has resume_vec_o=0. An interrupt wake leaves tmo_flag_o unchanged.
- R6: With osc_mode_i=0 (RC), osc_en_o rises on the edge that registers the wake. core_clk_en_o rises on the edge after that.
- R7: With osc_mode_i=1 (crystal), osc_en_o rises on the edge that registers the wake. core_clk_en_o rises STARTUP_CYC+1 edges later.
- R8: resume_o is a one-cycle pulse on the edge where core_clk_en_o returns after a wake. While it is high, resume_vec_o equals irq_global_en_i AND (an enabled interrupt was pending), both taken at the wake edge.
- R9: While ext_rst_n_i=0, from the next edge on:
  - core_rst_o=1, osc_en_o=1 and core_clk_en_o=1;
  - both flags keep their values;
  - a sleep in progress ends without a resume pulse.
- R10: A wdt_clr_i strobe while awake sets both flags to 1 and produces a one-cycle wdt_clr_o pulse on the next edge.
- R11: A wdt_timeout_i pulse while awake clears tmo_flag_o, leaves pwrdn_flag_o unchanged and gives a one-cycle core_rst_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_i | input | 1 | Core retired a sleep instruction |
| wdt_clr_i | input | 1 | Core retired a watchdog-clear instruction |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| irq_flag_i | input | N_IRQ | Per-source interrupt flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| irq_global_en_i | input | 1 | Global interrupt enable |
| osc_mode_i | input | 1 | 0 = RC, 1 = crystal (start-up delay) |
| osc_en_o | output | 1 | Oscillator driver enable |
| core_clk_en_o | output | 1 | Core instruction clock enable |
| pwrdn_flag_o | output | 1 | Power-down status flag |
| tmo_flag_o | output | 1 | Time-out status flag (0 after watchdog time-out) |
| wdt_clr_o | output | 1 | Watchdog and postscaler clear pulse |
| core_rst_o | output | 1 | Core reset |
| resume_o | output | 1 | One-cycle pulse: core may resume |
| resume_vec_o | output | 1 | On resume: 1 = vector after dummy cycle, 0 = continue in line |

## Verification
The bench raises a sleep strobe while an enabled interrupt is already pending. A design that fails to block entry would clear the power-down flag and stop the clock, so the core would sleep through an interrupt that should have stopped it. The bench also holds a flag with its enable clear while the block is asleep, to catch a wake that ignores the enable. It checks resume_vec_o against each global-enable setting and against watchdog wakes, because a wrong vector decision sends the core to the handler at the wrong time.

It counts the crystal start-up interval edge by edge. A counter that is off by one shows up as core_clk_en_o returning one edge early or late. Finally it pulls the reset pin during sleep, to catch a design that disturbs the flags or emits a stray resume pulse.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE       = 2'd0,
    ST_ASLEEP      = 2'd1,
    ST_OSC_STARTUP = 2'd2,
    ST_RESUME      = 2'd3
  } swc_state_e;

  typedef enum logic {
    OSC_RC   = 1'b0,
    OSC_XTAL = 1'b1
  } swc_osc_e;
endpackage

// File: rtl/swc_startup_cnt.sv
`timescale 1ns/1ps
module swc_startup_cnt #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R7
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/swc_status.sv
`timescale 1ns/1ps
module swc_status (
  input  logic clk,
  input  logic rst,
  input  logic sleep_take_i,
  input  logic wdt_set_i,
  input  logic tmo_clr_i,
  output logic pwrdn_flag_o,
  output logic tmo_flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwrdn_flag_o <= 1'b1;
      tmo_flag_o   <= 1'b1;
    end else if (tmo_clr_i) begin
      tmo_flag_o   <= 1'b0;
    end else if (sleep_take_i) begin
      pwrdn_flag_o <= 1'b0;
      tmo_flag_o   <= 1'b1;
    end else if (wdt_set_i) begin
      pwrdn_flag_o <= 1'b1;
      tmo_flag_o   <= 1'b1;
    end
  end

  AST_SLEEP_STATUS: assert property (@(posedge clk) disable iff (rst)
    sleep_take_i && !tmo_clr_i |=> !pwrdn_flag_o && tmo_flag_o); // R2
  AST_WDT_SET_STATUS: assert property (@(posedge clk) disable iff (rst)
    wdt_set_i && !sleep_take_i && !tmo_clr_i |=> pwrdn_flag_o && tmo_flag_o); // R10
  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    tmo_clr_i |=> !tmo_flag_o); // R5
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tmo_clr_i && !sleep_take_i && !wdt_set_i |=> $stable(pwrdn_flag_o) && $stable(tmo_flag_o)); // R9
endmodule

// File: rtl/sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_IRQ       = 3,
  parameter int STARTUP_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             wdt_clr_i,
  input  logic             ext_rst_n_i,
  input  logic             wdt_timeout_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             irq_global_en_i,
  input  logic             osc_mode_i,
  output logic             osc_en_o,
  output logic             core_clk_en_o,
  output logic             pwrdn_flag_o,
  output logic             tmo_flag_o,
  output logic             wdt_clr_o,
  output logic             core_rst_o,
  output logic             resume_o,
  output logic             resume_vec_o
);
  swc_state_e state_q;

  logic irq_pend;
  logic ext_rst_act;
  logic awake_free;
  logic sleep_take;
  logic wdt_set;
  logic tmo_clr;
  logic wake_now;
  logic cnt_run;
  logic cnt_done;

  // Pending check is sampled in the same cycle as the sleep strobe.
  assign irq_pend    = |(irq_flag_i & irq_en_i);
  assign ext_rst_act = !ext_rst_n_i;
  assign awake_free  = (state_q == ST_AWAKE) && !ext_rst_act && !wdt_timeout_i;
  assign sleep_take  = awake_free && sleep_i && !irq_pend;
  assign wdt_set     = awake_free && !sleep_take && wdt_clr_i;
  assign tmo_clr     = !ext_rst_act && wdt_timeout_i &&
                       ((state_q == ST_AWAKE) || (state_q == ST_ASLEEP));
  assign wake_now    = (state_q == ST_ASLEEP) && !ext_rst_act &&
                       (irq_pend || wdt_timeout_i);
  assign cnt_run     = (state_q == ST_OSC_STARTUP) && !ext_rst_act;

  swc_status u_status (
    .clk          (clk),
    .rst          (rst),
    .sleep_take_i (sleep_take),
    .wdt_set_i    (wdt_set),
    .tmo_clr_i    (tmo_clr),
    .pwrdn_flag_o (pwrdn_flag_o),
    .tmo_flag_o   (tmo_flag_o)
  );

  swc_startup_cnt #(.CYCLES(STARTUP_CYC)) u_startup (
    .clk    (clk),
    .rst    (rst),
    .run_i  (cnt_run),
    .done_o (cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_AWAKE;
      osc_en_o      <= 1'b1;
      core_clk_en_o <= 1'b1;
      wdt_clr_o     <= 1'b0;
      core_rst_o    <= 1'b0;
      resume_o      <= 1'b0;
      resume_vec_o  <= 1'b0;
    end else begin
      wdt_clr_o  <= 1'b0;
      resume_o   <= 1'b0;
      core_rst_o <= ext_rst_act;
      if (ext_rst_act) begin
        state_q       <= ST_AWAKE;
        osc_en_o      <= 1'b1;
        core_clk_en_o <= 1'b1;
      end else begin
        unique case (state_q)
          ST_AWAKE: begin
            if (wdt_timeout_i) begin
              core_rst_o <= 1'b1;
            end else if (sleep_take) begin
              state_q       <= ST_ASLEEP;
              osc_en_o      <= 1'b0;
              core_clk_en_o <= 1'b0;
              wdt_clr_o     <= 1'b1;
            end else if (wdt_set) begin
              wdt_clr_o <= 1'b1;
            end
          end
          ST_ASLEEP: begin
            if (wake_now) begin
              osc_en_o     <= 1'b1;
              resume_vec_o <= irq_global_en_i && irq_pend;
              state_q      <= (swc_osc_e'(osc_mode_i) == OSC_XTAL) ?
                              ST_OSC_STARTUP : ST_RESUME;
            end
          end
          ST_OSC_STARTUP: begin
            if (cnt_done) state_q <= ST_RESUME;
          end
          ST_RESUME: begin
            state_q       <= ST_AWAKE;
            core_clk_en_o <= 1'b1;
            resume_o      <= 1'b1;
          end
          default: state_q <= ST_AWAKE;
        endcase
      end
    end
  end

  AST_PENDING_NOP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AWAKE) && ext_rst_n_i && !wdt_timeout_i && !wdt_clr_i && sleep_i && irq_pend
    |=> $stable(pwrdn_flag_o) && $stable(tmo_flag_o) && !wdt_clr_o && core_clk_en_o); // R3
  AST_ASLEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ASLEEP) |-> !osc_en_o && !core_clk_en_o); // R2
  AST_WDT_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wdt_clr_o |=> !wdt_clr_o); // R10
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resume_o |=> !resume_o); // R8
  AST_RESUME_CLK_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_o) |-> $rose(core_clk_en_o)); // R8
  AST_EXT_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n_i |=> core_rst_o && osc_en_o && core_clk_en_o && !resume_o
                     && $stable(pwrdn_flag_o) && $stable(tmo_flag_o)); // R9
  AST_STARTUP_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OSC_STARTUP) |-> osc_en_o && !core_clk_en_o); // R7
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;
  localparam int N_IRQ       = 3;
  localparam int STARTUP_CYC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0;
  logic wdt_clr_i = 1'b0;
  logic ext_rst_n_i = 1'b1;
  logic wdt_timeout_i = 1'b0;
  logic [N_IRQ-1:0] irq_flag_i = '0;
  logic [N_IRQ-1:0] irq_en_i = '0;
  logic irq_global_en_i = 1'b0;
  logic osc_mode_i = 1'b0;
  logic osc_en_o, core_clk_en_o, pwrdn_flag_o, tmo_flag_o;
  logic wdt_clr_o, core_rst_o, resume_o, resume_vec_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .STARTUP_CYC(STARTUP_CYC)) u_dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i),
    .ext_rst_n_i(ext_rst_n_i), .wdt_timeout_i(wdt_timeout_i),
    .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i),
    .irq_global_en_i(irq_global_en_i), .osc_mode_i(osc_mode_i),
    .osc_en_o(osc_en_o), .core_clk_en_o(core_clk_en_o),
    .pwrdn_flag_o(pwrdn_flag_o), .tmo_flag_o(tmo_flag_o),
    .wdt_clr_o(wdt_clr_o), .core_rst_o(core_rst_o),
    .resume_o(resume_o), .resume_vec_o(resume_vec_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Enter sleep with no pending interrupt; checks R2.
  task automatic go_sleep();
    sleep_i = 1'b1;
    step();
    sleep_i = 1'b0;
    check("R2", "pwrdn", pwrdn_flag_o, 1'b0);
    check("R2", "tmo", tmo_flag_o, 1'b1);
    check("R2", "wdt_clr", wdt_clr_o, 1'b1);
    check("R2", "osc_en", osc_en_o, 1'b0);
    check("R2", "clk_en", core_clk_en_o, 1'b0);
    step();
    check("R2", "wdt_clr one cycle", wdt_clr_o, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", "pwrdn", pwrdn_flag_o, 1'b1);
    check("R1", "tmo", tmo_flag_o, 1'b1);
    check("R1", "osc_en", osc_en_o, 1'b1);
    check("R1", "clk_en", core_clk_en_o, 1'b1);
    check("R1", "resume", resume_o, 1'b0);
    check("R1", "core_rst", core_rst_o, 1'b0);
    check("R1", "wdt_clr", wdt_clr_o, 1'b0);
  endtask

  task automatic t_wdt_clear();
    wdt_clr_i = 1'b1;
    step();
    wdt_clr_i = 1'b0;
    check("R10", "wdt_clr", wdt_clr_o, 1'b1);
    check("R10", "pwrdn", pwrdn_flag_o, 1'b1);
    check("R10", "tmo", tmo_flag_o, 1'b1);
    step();
    check("R10", "wdt_clr one cycle", wdt_clr_o, 1'b0);
  endtask

  task automatic t_rc_irq_wake(input logic gie);
    osc_mode_i = 1'b0;
    go_sleep();
    irq_flag_i[0] = 1'b1;
    irq_en_i[0]   = 1'b0;
    for (int i = 0; i < 4; i++) step();
    check("R4", "disabled flag keeps osc off", osc_en_o, 1'b0);
    check("R4", "disabled flag keeps clk off", core_clk_en_o, 1'b0);
    irq_global_en_i = gie;
    irq_flag_i[2] = 1'b1;
    irq_en_i[2]   = 1'b1;
    step();
    irq_flag_i = '0;
    irq_en_i   = '0;
    check("R6", "osc_en at wake edge", osc_en_o, 1'b1);
    check("R6", "clk_en not yet", core_clk_en_o, 1'b0);
    step();
    check("R6", "clk_en back", core_clk_en_o, 1'b1);
    check("R8", "resume pulse", resume_o, 1'b1);
    check("R8", "resume_vec", resume_vec_o, gie);
    check("R5", "irq wake keeps tmo", tmo_flag_o, 1'b1);
    step();
    check("R8", "resume one cycle", resume_o, 1'b0);
    irq_global_en_i = 1'b0;
  endtask

  task automatic t_xtal_wdt_wake();
    osc_mode_i = 1'b1;
    irq_global_en_i = 1'b1;
    go_sleep();
    wdt_timeout_i = 1'b1;
    step();
    wdt_timeout_i = 1'b0;
    check("R5", "tmo cleared", tmo_flag_o, 1'b0);
    check("R7", "osc_en at wake edge", osc_en_o, 1'b1);
    check("R7", "clk_en off", core_clk_en_o, 1'b0);
    for (int i = 0; i < STARTUP_CYC; i++) step();
    check("R7", "clk_en still off after STARTUP_CYC edges", core_clk_en_o, 1'b0);
    step();
    check("R7", "clk_en back", core_clk_en_o, 1'b1);
    check("R8", "resume pulse", resume_o, 1'b1);
    check("R5", "wdt wake continues in line", resume_vec_o, 1'b0);
    check("R5", "pwrdn stays clear", pwrdn_flag_o, 1'b0);
    step();
    check("R8", "resume one cycle", resume_o, 1'b0);
    irq_global_en_i = 1'b0;
    osc_mode_i = 1'b0;
  endtask

  task automatic t_pending_nop();
    t_wdt_clear();
    irq_flag_i[1] = 1'b1;
    irq_en_i[1]   = 1'b1;
    sleep_i = 1'b1;
    step();
    sleep_i = 1'b0;
    check("R3", "pwrdn unchanged", pwrdn_flag_o, 1'b1);
    check("R3", "tmo unchanged", tmo_flag_o, 1'b1);
    check("R3", "no wdt_clr", wdt_clr_o, 1'b0);
    check("R3", "clk_en on", core_clk_en_o, 1'b1);
    check("R3", "osc_en on", osc_en_o, 1'b1);
    irq_flag_i = '0;
    irq_en_i   = '0;
    step();
    check("R3", "still awake", core_clk_en_o, 1'b1);
  endtask

  task automatic t_ext_reset();
    go_sleep();
    ext_rst_n_i = 1'b0;
    step();
    check("R9", "core_rst", core_rst_o, 1'b1);
    check("R9", "osc_en", osc_en_o, 1'b1);
    check("R9", "clk_en", core_clk_en_o, 1'b1);
    check("R9", "pwrdn unchanged", pwrdn_flag_o, 1'b0);
    check("R9", "tmo unchanged", tmo_flag_o, 1'b1);
    step();
    step();
    check("R9", "core_rst held", core_rst_o, 1'b1);
    check("R9", "no resume", resume_o, 1'b0);
    ext_rst_n_i = 1'b1;
    step();
    check("R9", "core_rst released", core_rst_o, 1'b0);
    check("R9", "no resume after release", resume_o, 1'b0);
  endtask

  task automatic t_wdt_awake();
    t_wdt_clear();
    wdt_timeout_i = 1'b1;
    step();
    wdt_timeout_i = 1'b0;
    check("R11", "core_rst pulse", core_rst_o, 1'b1);
    check("R11", "tmo cleared", tmo_flag_o, 1'b0);
    check("R11", "pwrdn unchanged", pwrdn_flag_o, 1'b1);
    step();
    check("R11", "core_rst one cycle", core_rst_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_wdt_clear();
    t_rc_irq_wake(1'b0);
    t_rc_irq_wake(1'b1);
    t_xtal_wdt_wake();
    t_pending_nop();
    t_ext_reset();
    t_wdt_awake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule